// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that finishes each instruction in one clock. The instruction is fetched, its operands are read, the ALU computes, data memory is accessed and the result is written back, all within that clock. The core runs a small load/store instruction set: word load, word store, add, subtract, AND, OR, signed set-less-than and branch-if-equal. Instruction memory, data memory and the 32-entry register file are internal arrays. The memories read combinationally and write on the rising clock edge. All state changes on that same edge.

Memories are filled through a preload stream while the core is held in synchronous reset. The stream is valid/ready: `prog_ready` is high exactly while `rst` is high. A word is written on a rising edge where both `prog_valid` and `prog_ready` are high. Holding `prog_valid` high with `prog_ready` low writes nothing and waits; there is no other back-pressure. Once reset is released, the core executes from byte address 0. For observation it exposes the program counter, the register write-back bus and the data store bus.

Top module: `sc_core`

## Requirements
- R1: A clock edge with `rst` high sets the PC to 0 and clears all registers. `prog_ready` equals `rst`. While `rst` is high, an accepted preload word is written into instruction memory (`prog_sel`=0) or data memory (`prog_sel`=1) at word index `prog_addr`, and the core performs no write-back or store. Preload words offered while `rst` is low are ignored.
- R2: The PC is a byte address. The instruction fetched is the instruction-memory word at index PC[IAW+1:2], wrapping modulo the depth. Every instruction except a taken branch makes the next PC equal PC+4.
- R3: Opcode bits [31:26]=0x00 with shamt [10:6]=0 and funct [5:0] 0x20/0x22/0x24/0x25 writes reg[rd [15:11]] with reg[rs [25:21]] +, −, AND or OR reg[rt [20:16]].
- R4: Funct 0x2A (same R-type frame) writes 1 to rd when reg[rs] < reg[rt] as signed two's-complement values, and 0 otherwise.
- R5: Opcode 0x23 writes reg[rt] with the data-memory word at index A[DAW+1:2], where A = reg[rs] + sign-extended imm [15:0].
- R6: Opcode 0x2B writes reg[rt] into the data-memory word at index A[DAW+1:2] (A as in R5). It shows `st_en_o`=1 with A and the data, and performs no register write.
- R7: Opcode 0x04 sets the next PC to PC+4+sext(imm)*4 when reg[rs]==reg[rt], and to PC+4 otherwise. It writes nothing.
- R8: Register 0 always reads as zero. A result aimed at register 0 is dropped, and `wb_en_o` stays low for it.
- R9: Any other opcode, any other funct, or an R-type word with nonzero shamt is a no-op: no write-back, no store, PC+4.
- R10: A result written by one instruction is the operand value seen by the very next instruction. Register and memory results are therefore visible with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prog_valid | input | 1 | Preload word offered |
| prog_ready | output | 1 | Preload accepted (high while in reset) |
| prog_sel | input | 1 | Preload target: 0 instruction, 1 data memory |
| prog_addr | input | PAW | Preload word index |
| prog_data | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| wb_en_o | output | 1 | Register write happening this cycle |
| wb_addr_o | output | 5 | Register written |
| wb_data_o | output | 32 | Value written |
| st_en_o | output | 1 | Data store happening this cycle |
| st_addr_o | output | 32 | Store byte address |
| st_data_o | output | 32 | Store data |

## Verification
The bench targets several corner cases, each with a distinct failure signature:
- Signed set-less-than with a negative operand: an unsigned compare inverts that result.
- Branches with negative offsets and branches comparing a register with itself: a target off by one word, or a missing sign extension, shows on `pc_o` one cycle later.
- Results aimed at register 0, followed by reads of register 0: a design that stores them later sources a nonzero operand.
- A store followed at once by a load of the same word, and a load straight after a register write: any pipelining or stale read returns the old value.
- Unknown opcodes, unknown funct codes, nonzero shamt, and preload writes offered after reset: a design that acts on these makes a spurious write or changes the program it runs.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int NREG   = 1 << REG_AW;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rt;
    logic    use_imm;
    logic    mem_rd;
    logic    mem_we;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode import sc_pkg::*; (
  input  logic [XLEN-1:0] instr,
  output ctrl_t           ctrl
);
  logic [5:0] op;
  logic [5:0] fn;
  logic [4:0] sh;

  assign op = instr[31:26];
  assign fn = instr[5:0];
  assign sh = instr[10:6];

  always_comb begin
    ctrl = '{reg_we: 1'b0, dst_rt: 1'b0, use_imm: 1'b0, mem_rd: 1'b0,
             mem_we: 1'b0, branch: 1'b0, alu_op: ALU_ADD};
    case (op)
      OP_RTYPE: begin
        if (sh == 5'd0) begin
          ctrl.reg_we = 1'b1;
          case (fn)
            FN_ADD:  ctrl.alu_op = ALU_ADD;
            FN_SUB:  ctrl.alu_op = ALU_SUB;
            FN_AND:  ctrl.alu_op = ALU_AND;
            FN_OR:   ctrl.alu_op = ALU_OR;
            FN_SLT:  ctrl.alu_op = ALU_SLT;
            default: ctrl.reg_we = 1'b0;
          endcase
        end
      end
      OP_LOAD: begin
        ctrl.reg_we  = 1'b1;
        ctrl.dst_rt  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.mem_rd  = 1'b1;
      end
      OP_STORE: begin
        ctrl.use_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile import sc_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [XLEN-1:0]   wdata,
  input  logic [REG_AW-1:0] raddr_a,
  input  logic [REG_AW-1:0] raddr_b,
  output logic [XLEN-1:0]   rdata_a,
  output logic [XLEN-1:0]   rdata_b
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/sc_alu.sv
module sc_alu import sc_pkg::*; (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ridx,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/sc_core.sv
module sc_core import sc_pkg::*; #(
  parameter int  IMEM_DEPTH = 64,
  parameter int  DMEM_DEPTH = 64,
  localparam int IAW = $clog2(IMEM_DEPTH),
  localparam int DAW = $clog2(DMEM_DEPTH),
  localparam int PAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_valid,
  output logic              prog_ready,
  input  logic              prog_sel,
  input  logic [PAW-1:0]    prog_addr,
  input  logic [XLEN-1:0]   prog_data,
  output logic [XLEN-1:0]   pc_o,
  output logic              wb_en_o,
  output logic [REG_AW-1:0] wb_addr_o,
  output logic [XLEN-1:0]   wb_data_o,
  output logic              st_en_o,
  output logic [XLEN-1:0]   st_addr_o,
  output logic [XLEN-1:0]   st_data_o
);
  logic [XLEN-1:0]   pc_q, pc_next, pc_plus4, br_target;
  logic [XLEN-1:0]   instr;
  ctrl_t             ctrl;
  logic [REG_AW-1:0] rs_a, rt_a, rd_a;
  logic [XLEN-1:0]   rs_data, rt_data, imm_ext, alu_b, alu_y, dm_rdata;
  logic              alu_zero, br_taken;
  logic              im_we, dm_we;
  logic [DAW-1:0]    dm_widx;
  logic [XLEN-1:0]   dm_wdata;

  // Preload stream handshake: only accepted while the core is in reset.
  assign prog_ready = rst;
  assign im_we      = prog_valid && prog_ready && !prog_sel;

  sc_mem #(.DEPTH(IMEM_DEPTH), .W(XLEN)) u_imem (
    .clk(clk), .we(im_we), .widx(prog_addr[IAW-1:0]), .wdata(prog_data),
    .ridx(pc_q[IAW+1:2]), .rdata(instr)
  );

  sc_decode u_dec (.instr(instr), .ctrl(ctrl));

  assign rs_a = instr[25:21];
  assign rt_a = instr[20:16];
  assign rd_a = instr[15:11];

  sc_regfile u_rf (
    .clk(clk), .rst(rst), .we(wb_en_o), .waddr(wb_addr_o), .wdata(wb_data_o),
    .raddr_a(rs_a), .raddr_b(rt_a), .rdata_a(rs_data), .rdata_b(rt_data)
  );

  assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign alu_b   = ctrl.use_imm ? imm_ext : rt_data;

  sc_alu u_alu (.a(rs_data), .b(alu_b), .op(ctrl.alu_op), .y(alu_y), .zero(alu_zero));

  // Data memory port: preload during reset, core stores afterwards.
  assign st_en_o   = ctrl.mem_we && !rst;
  assign st_addr_o = alu_y;
  assign st_data_o = rt_data;
  assign dm_we     = rst ? (prog_valid && prog_sel) : st_en_o;
  assign dm_widx   = rst ? prog_addr[DAW-1:0] : alu_y[DAW+1:2];
  assign dm_wdata  = rst ? prog_data : rt_data;

  sc_mem #(.DEPTH(DMEM_DEPTH), .W(XLEN)) u_dmem (
    .clk(clk), .we(dm_we), .widx(dm_widx), .wdata(dm_wdata),
    .ridx(alu_y[DAW+1:2]), .rdata(dm_rdata)
  );

  // Write-back: a result aimed at register 0 is not reported or stored.
  assign wb_addr_o = ctrl.dst_rt ? rt_a : rd_a;
  assign wb_data_o = ctrl.mem_rd ? dm_rdata : alu_y;
  assign wb_en_o   = ctrl.reg_we && !rst && (wb_addr_o != '0);

  // Next-address logic.
  assign br_taken  = ctrl.branch && alu_zero;
  assign pc_plus4  = pc_q + 32'd4;
  assign br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign pc_next   = br_taken ? br_target : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [31:0] rs_data,
  input logic        br_taken,
  input logic        wb_en,
  input logic [4:0]  wb_addr,
  input logic        st_en
);
  logic known_op;
  assign known_op = (instr[31:26] == 6'h00) || (instr[31:26] == 6'h23) ||
                    (instr[31:26] == 6'h2B) || (instr[31:26] == 6'h04);

  // R1: reset forces the PC to zero
  a_r1_pc_reset: assert property (@(posedge clk) rst |=> (pc == 32'd0));

  // R1: no architectural write while in reset
  a_r1_quiet_in_reset: assert property (@(posedge clk) rst |-> (!wb_en && !st_en));

  // R2: sequential flow advances by one word
  a_r2_seq_pc: assert property (@(posedge clk) disable iff (rst)
    !br_taken |=> (pc == $past(pc) + 32'd4));

  // R7: taken branch lands on the sign-extended word offset
  a_r7_branch_target: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> (pc == $past(pc) + 32'd4 +
                  {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}));

  // R6: a store never writes a register in the same cycle
  a_r6_store_no_wb: assert property (@(posedge clk) disable iff (rst)
    st_en |-> !wb_en);

  // R8: register 0 reads as zero
  a_r8_r0_zero: assert property (@(posedge clk) disable iff (rst)
    (instr[25:21] == 5'd0) |-> (rs_data == 32'd0));

  // R8: write-back never targets register 0
  a_r8_no_r0_write: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (wb_addr != 5'd0));

  // R9: unknown opcodes have no side effect
  a_r9_unknown_op: assert property (@(posedge clk) disable iff (rst)
    !known_op |-> (!wb_en && !st_en && !br_taken));
endmodule

bind sc_core sc_core_chk u_chk (
  .clk(clk), .rst(rst), .pc(pc_q), .instr(instr), .rs_data(rs_data),
  .br_taken(br_taken), .wb_en(wb_en_o), .wb_addr(wb_addr_o), .st_en(st_en_o)
);

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;
  localparam int IAW = 6;
  localparam int DAW = 6;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prog_valid = 1'b0;
  logic        prog_ready;
  logic        prog_sel = 1'b0;
  logic [5:0]  prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic [31:0] pc_o, wb_data_o, st_addr_o, st_data_o;
  logic        wb_en_o, st_en_o;
  logic [4:0]  wb_addr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] m_imem [DEPTH];
  logic [31:0] m_dmem [DEPTH];
  logic [31:0] m_reg  [32];
  logic [31:0] m_pc;
  string       pc_tag;

  always #2.5 clk = ~clk;

  sc_core u_dut (
    .clk(clk), .rst(rst), .prog_valid(prog_valid), .prog_ready(prog_ready),
    .prog_sel(prog_sel), .prog_addr(prog_addr), .prog_data(prog_data),
    .pc_o(pc_o), .wb_en_o(wb_en_o), .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o),
    .st_en_o(st_en_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rt, input int rs, input logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  function automatic logic [31:0] rnd_instr();
    int k = $urandom_range(0, 11);
    int a = $urandom_range(0, 7);
    int b = $urandom_range(0, 7);
    int c = $urandom_range(0, 7);
    logic [15:0] off = 16'(($urandom_range(0, 63) - 32) * 4);
    logic [5:0] fns [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
    logic [5:0] bad [4] = '{6'h01, 6'h08, 6'h3F, 6'h0F};
    case (k)
      0, 1, 2, 3: return enc_r(fns[$urandom_range(0, 4)], a, b, c);
      4: return enc_r(6'h2A, a, b, c);
      5, 6: return enc_i(6'h23, a, b, off);
      7: return enc_i(6'h2B, a, b, off);
      8: return enc_i(6'h04, a, b, 16'(int'($urandom_range(0, 8)) - 4));
      9: return {bad[$urandom_range(0, 3)], 26'($urandom)};
      10: return {6'h00, a[4:0], b[4:0], c[4:0], 5'd0, 6'h21};
      default: return {6'h00, a[4:0], b[4:0], c[4:0], 5'd3, 6'h20};
    endcase
  endfunction

  task automatic load_word(input logic sel, input int idx, input logic [31:0] d);
    prog_valid = 1'b1; prog_sel = sel; prog_addr = idx[5:0]; prog_data = d;
    @(negedge clk);
    prog_valid = 1'b0;
  endtask

  // Reset, preload both memories from the model arrays, check reset state.
  task automatic reset_and_load();
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) load_word(1'b0, i, m_imem[i]);
    for (int i = 0; i < DEPTH; i++) load_word(1'b1, i, m_dmem[i]);
    #1;
    chk("R1", "pc in reset", pc_o, 32'd0);
    chk("R1", "ready in reset", {31'd0, prog_ready}, 32'd1);
    chk("R1", "wb quiet in reset", {31'd0, wb_en_o}, 32'd0);
    chk("R1", "store quiet in reset", {31'd0, st_en_o}, 32'd0);
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    m_pc = '0;
    pc_tag = "R1";
    @(negedge clk);
    rst = 1'b0;
  endtask

  // One instruction: compare ports with the model, then advance the model.
  task automatic step_check();
    logic [31:0] ins, a, b, sx, res, npc, sa;
    logic [5:0] op, fn;
    logic [4:0] rs, rt, rd, sh;
    logic e_we, e_st, valid;
    logic [4:0] e_wa;
    string tag;
    #1;
    ins = m_imem[m_pc[IAW+1:2]];
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    sh = ins[10:6]; fn = ins[5:0];
    a = m_reg[rs]; b = m_reg[rt];
    sx = {{16{ins[15]}}, ins[15:0]};
    e_we = 0; e_st = 0; e_wa = 0; res = 0; sa = 0; valid = 1;
    npc = m_pc + 32'd4;
    tag = "R9";
    case (op)
      6'h00: begin
        tag = "R3";
        case (fn)
          6'h20: res = a + b;
          6'h22: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          6'h2A: begin res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R4"; end
          default: valid = 0;
        endcase
        if (sh != 0) valid = 0;
        if (!valid) tag = "R9";
        e_we = valid; e_wa = rd;
      end
      6'h23: begin
        tag = "R5"; sa = a + sx; res = m_dmem[sa[DAW+1:2]]; e_we = 1; e_wa = rt;
      end
      6'h2B: begin
        tag = "R6"; sa = a + sx; e_st = 1;
      end
      6'h04: begin
        tag = "R7";
        if (a == b) npc = m_pc + 32'd4 + {sx[29:0], 2'b00};
      end
      default: ;
    endcase
    if (e_we && e_wa == 0) begin e_we = 0; tag = "R8"; end
    chk(pc_tag, "pc", pc_o, m_pc);
    chk(tag, "wb_en", {31'd0, wb_en_o}, {31'd0, e_we});
    if (e_we) begin
      chk(tag, "wb_addr", {27'd0, wb_addr_o}, {27'd0, e_wa});
      chk(tag, "wb_data", wb_data_o, res);
    end
    chk(tag, "st_en", {31'd0, st_en_o}, {31'd0, e_st});
    if (e_st) begin
      chk("R6", "st_addr", st_addr_o, sa);
      chk("R6", "st_data", st_data_o, b);
    end
    if (e_we) m_reg[e_wa] = res;
    if (e_st) m_dmem[sa[DAW+1:2]] = b;
    pc_tag = (op == 6'h04) ? "R7" : "R2";
    m_pc = npc;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // Directed program.
    for (int i = 0; i < DEPTH; i++) begin m_imem[i] = 32'h0; m_dmem[i] = $urandom; end
    m_dmem[0] = 32'd5;
    m_dmem[1] = 32'hFFFF_FFFD;
    m_imem[0]  = enc_i(6'h23, 1, 0, 16'd0);        // R5 r1=5
    m_imem[1]  = enc_i(6'h23, 2, 0, 16'd4);        // R5 r2=-3, R10 use next
    m_imem[2]  = enc_r(6'h20, 3, 1, 2);            // R3 add
    m_imem[3]  = enc_r(6'h22, 4, 1, 2);            // R3 sub
    m_imem[4]  = enc_r(6'h24, 5, 1, 2);            // R3 and
    m_imem[5]  = enc_r(6'h25, 6, 1, 2);            // R3 or
    m_imem[6]  = enc_r(6'h2A, 7, 2, 1);            // R4 signed -3<5 -> 1
    m_imem[7]  = enc_r(6'h2A, 8, 1, 2);            // R4 -> 0
    m_imem[8]  = enc_r(6'h20, 0, 1, 1);            // R8 write to r0 dropped
    m_imem[9]  = enc_r(6'h20, 9, 0, 1);            // R8 r0 reads zero
    m_imem[10] = enc_i(6'h2B, 3, 0, 16'd12);       // R6 store
    m_imem[11] = enc_i(6'h23, 10, 0, 16'd12);      // R10 load same word
    m_imem[12] = enc_i(6'h04, 2, 1, 16'd5);        // R7 not taken
    m_imem[13] = enc_i(6'h04, 7, 7, 16'd2);        // R7 taken forward
    m_imem[14] = enc_r(6'h20, 11, 1, 1);
    m_imem[15] = enc_r(6'h20, 11, 1, 1);
    m_imem[16] = 32'hFC00_0000;                    // R9 unknown opcode
    m_imem[17] = {6'h00, 5'd1, 5'd1, 5'd12, 5'd0, 6'h00}; // R9 unknown funct
    m_imem[18] = enc_i(6'h04, 0, 0, 16'hFFFF);     // R7 negative offset, self loop
    reset_and_load();
    // R1: preload offered after reset must not alter the running program.
    prog_valid = 1'b1; prog_sel = 1'b0; prog_addr = 6'd18;
    prog_data = enc_r(6'h20, 12, 1, 1);
    for (int i = 0; i < 30; i++) step_check();
    chk("R1", "ready after reset", {31'd0, prog_ready}, 32'd0);
    prog_valid = 1'b0;

    // Random programs.
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < DEPTH; i++) begin
        m_imem[i] = rnd_instr();
        m_dmem[i] = ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 9)) - 32'd4 : $urandom;
      end
      for (int i = 1; i < 8; i++) m_imem[i - 1] = enc_i(6'h23, i, 0, 16'(i * 4));
      reset_and_load();
      for (int i = 0; i < 400; i++) step_check();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule